// File: doc/BRIEF.md
# Banked Block Copy Engine

This block performs the two block-copy instructions of a processor with 24-bit banked addressing. When it is idle, a start pulse latches the source and destination bank bytes, the X, Y and accumulator register values, a direction bit and the index-width flag. It then copies one byte at a time through a single memory port. For each byte it reads from the source bank at the offset held in X, then writes that byte to the destination bank at the offset held in Y.

After each byte is written, X and Y step up or down together and the accumulator counts down by one. The copy ends when the accumulator passes below zero, so a start value of N moves N+1 bytes. The working registers are visible on the ports during the copy and afterwards, so the processor can load them back. When the copy completes, the data-bank output takes the destination bank.

Top module: `bmove_engine`

## Requirements
- R1: While reset is high, and in the cycle after it is released, busy, done, mem_rd and mem_wr are 0, and mem_addr, x_out, y_out, acc_out and dbank_out are all zero.
- R2: A start pulse seen in an idle cycle makes the next cycle a read cycle (busy=1, mem_rd=1) at address {src_bank, X}.
- R3: Every byte takes exactly one read cycle followed by one write cycle. The write goes to {dst_bank, Y}, and mem_wdata equals the mem_rdata presented during the preceding read cycle.
- R4: The number of bytes moved is acc_in+1. acc_out decrements by one after each write and ends at 0xFFFF.
- R5: With move_down=0, X and Y increment by one after each byte. With move_down=1, they decrement by one.
- R6: The 16-bit offsets wrap within their bank (0xFFFF+1 gives 0x0000, and 0x0000-1 gives 0xFFFF). The bank byte on mem_addr[23:16] never changes during a copy.
- R7: With index_narrow=1, the upper byte of X and Y is forced to zero when they are latched. Stepping wraps within the low 8 bits, so both mem_addr[15:8] and the upper byte of x_out and y_out stay zero.
- R8: done is a single-cycle pulse in the cycle after the last write cycle, with busy=0. From that cycle on, dbank_out equals the destination bank.
- R9: A start pulse arriving while a copy is in progress is ignored and does not change the copy.
- R10: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a copy (accepted only when idle) |
| move_down | input | 1 | 0: offsets count up, 1: offsets count down |
| index_narrow | input | 1 | Index registers are 8 bits wide |
| src_bank | input | 8 | Source bank byte |
| dst_bank | input | 8 | Destination bank byte |
| x_in | input | 16 | Initial source offset |
| y_in | input | 16 | Initial destination offset |
| acc_in | input | 16 | Byte count minus one |
| mem_rdata | input | 8 | Read data, valid in the read cycle |
| mem_addr | output | 24 | Memory address {bank, offset} |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Current or final X |
| y_out | output | 16 | Current or final Y |
| acc_out | output | 16 | Current or final accumulator |
| dbank_out | output | 8 | Data bank after completion |

## Verification
A wrong pointer step or count shows up at the ports one cycle later. It appears as a wrong mem_addr on the next read or write cycle, or as a wrong x_out, y_out or acc_out. A state-machine error shows up at once, as a strobe in the wrong cycle or a done pulse that is early, late or repeated. The bench mirrors the copy cycle by cycle and compares every output on every clock. It covers wrapping offsets, narrow indices, downward moves, a single-byte copy and a start pulse sent during a copy, so each fault is reported within one cycle of its cause.

// File: rtl/bmove_pkg.sv
package bmove_pkg;

    localparam int OFF_W    = 16;
    localparam int BANK_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NARROW_W = 8;
    localparam int ADDR_W   = BANK_W + OFF_W;
    localparam int SIDES    = 2;

    localparam logic [OFF_W-1:0] PTR_ONE = OFF_W'(1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } mv_state_e;

    typedef struct packed {
        logic              down;
        logic              narrow;
        logic [BANK_W-1:0] src_bank;
        logic [BANK_W-1:0] dst_bank;
    } mv_cfg_t;

    typedef struct packed {
        logic [OFF_W-1:0] src;
        logic [OFF_W-1:0] dst;
        logic [OFF_W-1:0] cnt;
    } mv_regs_t;

    // Force the upper byte to zero when the index registers are narrow.
    function automatic logic [OFF_W-1:0] clip_ptr(logic [OFF_W-1:0] p, logic narrow);
        logic [OFF_W-1:0] r;
        r = p;
        if (narrow) r[OFF_W-1:NARROW_W] = '0;
        return r;
    endfunction

    // Step a pointer one position, wrapping inside its bank or its low byte.
    function automatic logic [OFF_W-1:0] step_ptr(logic [OFF_W-1:0] p, logic down, logic narrow);
        logic [OFF_W-1:0] r;
        r = down ? (p - PTR_ONE) : (p + PTR_ONE);
        return clip_ptr(r, narrow);
    endfunction

endpackage

// File: rtl/bmove_ctrl.sv
module bmove_ctrl
    import bmove_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cnt_last,
    output mv_state_e state,
    output logic      accept,
    output logic      step,
    output logic      finish
);

    assign accept = (state == ST_IDLE) && start;
    assign step   = (state == ST_WRITE);
    assign finish = step && cnt_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (start) state <= ST_READ;
                ST_READ:  state <= ST_WRITE;
                ST_WRITE: state <= cnt_last ? ST_FIN : ST_READ;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R8
    fin_once_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_FIN |=> state == ST_IDLE);

    // R3
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        state == ST_READ |=> state == ST_WRITE);

endmodule

// File: rtl/bmove_regs.sv
module bmove_regs
    import bmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              step,
    input  logic              finish,
    input  mv_cfg_t           cfg_in,
    input  logic [OFF_W-1:0]  x_in,
    input  logic [OFF_W-1:0]  y_in,
    input  logic [OFF_W-1:0]  a_in,
    output mv_cfg_t           cfg,
    output mv_regs_t          regs,
    output logic              cnt_last,
    output logic [BANK_W-1:0] dbank
);

    assign cnt_last = (regs.cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            regs  <= '0;
            dbank <= '0;
        end else if (accept) begin
            cfg      <= cfg_in;
            regs.src <= clip_ptr(x_in, cfg_in.narrow);
            regs.dst <= clip_ptr(y_in, cfg_in.narrow);
            regs.cnt <= a_in;
        end else if (step) begin
            regs.src <= step_ptr(regs.src, cfg.down, cfg.narrow);
            regs.dst <= step_ptr(regs.dst, cfg.down, cfg.narrow);
            regs.cnt <= regs.cnt - PTR_ONE;
            if (finish) dbank <= cfg.dst_bank;
        end
    end

    // R4
    cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> regs.cnt == $past(regs.cnt) - PTR_ONE);

    // R7
    narrow_hi_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.narrow |-> (regs.src[OFF_W-1:NARROW_W] == '0) && (regs.dst[OFF_W-1:NARROW_W] == '0));

    // R9
    hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(cfg));

endmodule

// File: rtl/bmove_addr.sv
module bmove_addr
    import bmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mv_state_e         state,
    input  mv_cfg_t           cfg,
    input  mv_regs_t          regs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic [ADDR_W-1:0] side_addr [SIDES];
    logic [DATA_W-1:0] hold;

    // Side 0 is the source, side 1 the destination.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        if (s == 0) begin : g_src
            assign side_addr[s] = {cfg.src_bank, regs.src};
        end else begin : g_dst
            assign side_addr[s] = {cfg.dst_bank, regs.dst};
        end
    end

    assign mem_rd = (state == ST_READ);
    assign mem_wr = (state == ST_WRITE);

    always_comb begin
        mem_addr = '0;
        if (mem_rd)      mem_addr = side_addr[0];
        else if (mem_wr) mem_addr = side_addr[1];
    end

    always_ff @(posedge clk) begin
        if (rst)         hold <= '0;
        else if (mem_rd) hold <= mem_rdata;
    end

    assign mem_wdata = hold;

    // R3
    wdata_match_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_wdata == $past(mem_rdata));

    // R6
    src_bank_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> mem_addr[ADDR_W-1:OFF_W] == cfg.src_bank);

    // R6
    dst_bank_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> mem_addr[ADDR_W-1:OFF_W] == cfg.dst_bank);

endmodule

// File: rtl/bmove_engine.sv
module bmove_engine
    import bmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              move_down,
    input  logic              index_narrow,
    input  logic [BANK_W-1:0] src_bank,
    input  logic [BANK_W-1:0] dst_bank,
    input  logic [OFF_W-1:0]  x_in,
    input  logic [OFF_W-1:0]  y_in,
    input  logic [OFF_W-1:0]  acc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [OFF_W-1:0]  x_out,
    output logic [OFF_W-1:0]  y_out,
    output logic [OFF_W-1:0]  acc_out,
    output logic [BANK_W-1:0] dbank_out
);

    mv_state_e state;
    logic      accept, step, finish, cnt_last;
    mv_cfg_t   cfg_in, cfg;
    mv_regs_t  regs;

    assign cfg_in = '{down: move_down, narrow: index_narrow,
                      src_bank: src_bank, dst_bank: dst_bank};

    bmove_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cnt_last(cnt_last),
        .state(state), .accept(accept), .step(step), .finish(finish)
    );

    bmove_regs u_regs (
        .clk(clk), .rst(rst), .accept(accept), .step(step), .finish(finish),
        .cfg_in(cfg_in), .x_in(x_in), .y_in(y_in), .a_in(acc_in),
        .cfg(cfg), .regs(regs), .cnt_last(cnt_last), .dbank(dbank_out)
    );

    bmove_addr u_addr (
        .clk(clk), .rst(rst), .state(state), .cfg(cfg), .regs(regs),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    assign busy    = (state == ST_READ) || (state == ST_WRITE);
    assign done    = (state == ST_FIN);
    assign x_out   = regs.src;
    assign y_out   = regs.dst;
    assign acc_out = regs.cnt;

    // R10
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_bank_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && dbank_out == $past(dst_bank_seen));

    logic [BANK_W-1:0] dst_bank_seen;
    always_ff @(posedge clk) begin
        if (rst)         dst_bank_seen <= '0;
        else if (accept) dst_bank_seen <= dst_bank;
    end

endmodule

// File: tb/tb_bmove_engine.sv
module tb_bmove_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        move_down = 1'b0;
    logic        index_narrow = 1'b0;
    logic [7:0]  src_bank = '0, dst_bank = '0;
    logic [15:0] x_in = '0, y_in = '0, acc_in = '0;
    logic [7:0]  mem_rdata;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, busy, done;
    logic [7:0]  mem_wdata, dbank_out;
    logic [15:0] x_out, y_out, acc_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int wr_total = 0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(logic [23:0] a);
        return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign mem_rdata = pat(mem_addr);

    bmove_engine dut (
        .clk(clk), .rst(rst), .start(start), .move_down(move_down),
        .index_narrow(index_narrow), .src_bank(src_bank), .dst_bank(dst_bank),
        .x_in(x_in), .y_in(y_in), .acc_in(acc_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .x_out(x_out),
        .y_out(y_out), .acc_out(acc_out), .dbank_out(dbank_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 read, 2 write, 3 finished
    int          m_st = 0;
    logic        m_down = 0, m_nar = 0;
    logic [7:0]  m_sb = 0, m_dbk = 0, m_db = 0, m_byte = 0;
    logic [15:0] m_x = 0, m_y = 0, m_a = 0;

    function automatic logic [15:0] mstep(logic [15:0] p, logic down, logic nar);
        int v;
        v = down ? int'(p) - 1 : int'(p) + 1;
        v = nar ? (v & 'hFF) : (v & 'hFFFF);
        return v[15:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_x = 0; m_y = 0; m_a = 0; m_db = 0; m_byte = 0;
            m_sb = 0; m_dbk = 0; m_down = 0; m_nar = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_down = move_down; m_nar = index_narrow;
                    m_sb = src_bank; m_dbk = dst_bank;
                    m_x = index_narrow ? (x_in & 16'h00FF) : x_in;
                    m_y = index_narrow ? (y_in & 16'h00FF) : y_in;
                    m_a = acc_in;
                    m_st = 1;
                end
                1: begin
                    m_byte = pat({m_sb, m_x});
                    m_st = 2;
                end
                2: begin
                    m_x = mstep(m_x, m_down, m_nar);
                    m_y = mstep(m_y, m_down, m_nar);
                    if (m_a == 16'h0000) begin
                        m_st = 3;
                        m_db = m_dbk;
                    end else begin
                        m_st = 1;
                    end
                    m_a = m_a - 16'd1;
                end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            logic [23:0] ea;
            ea = (m_st == 1) ? {m_sb, m_x} : (m_st == 2) ? {m_dbk, m_y} : 24'h0;
            chk(mem_rd == (m_st == 1), "R3 mem_rd", 32'(mem_rd), 32'(m_st == 1));
            chk(mem_wr == (m_st == 2), "R3 mem_wr", 32'(mem_wr), 32'(m_st == 2));
            chk(mem_addr == ea, "R6 mem_addr", 32'(mem_addr), 32'(ea));
            if (m_st == 2) chk(mem_wdata == m_byte, "R3 mem_wdata", 32'(mem_wdata), 32'(m_byte));
            chk(busy == (m_st == 1 || m_st == 2), "R2 busy", 32'(busy), 32'(m_st == 1 || m_st == 2));
            chk(done == (m_st == 3), "R8 done", 32'(done), 32'(m_st == 3));
            chk(x_out == m_x, "R5 x_out", 32'(x_out), 32'(m_x));
            chk(y_out == m_y, "R5 y_out", 32'(y_out), 32'(m_y));
            chk(acc_out == m_a, "R4 acc_out", 32'(acc_out), 32'(m_a));
            chk(dbank_out == m_db, "R8 dbank_out", 32'(dbank_out), 32'(m_db));
            chk(!(mem_rd && mem_wr), "R10 exclusive strobes", 32'(mem_rd && mem_wr), 32'(0));
        end
        if (mem_wr) wr_total++;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_move(input string tag, input logic down, input logic nar,
                            input logic [7:0] sb, input logic [7:0] db,
                            input logic [15:0] x, input logic [15:0] y, input logic [15:0] a,
                            input logic [15:0] ex, input logic [15:0] ey, input bit poke);
        int w0;
        @(negedge clk);
        w0 = wr_total;
        move_down = down; index_narrow = nar; src_bank = sb; dst_bank = db;
        x_in = x; y_in = y; acc_in = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: first read cycle right after the start edge
        chk(mem_rd && mem_addr == {sb, nar ? (x & 16'h00FF) : x}, {"R2 first read ", tag},
            32'(mem_addr), 32'({sb, nar ? (x & 16'h00FF) : x}));
        if (poke) begin
            // R9: a second start during the copy with different values
            @(negedge clk);
            move_down = ~down; src_bank = ~sb; dst_bank = ~db;
            x_in = ~x; y_in = ~y; acc_in = 16'h0040; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(!busy, {"R8 busy low at done ", tag}, 32'(busy), 32'(0));
        chk(dbank_out == db, {"R8 dbank ", tag}, 32'(dbank_out), 32'(db));
        @(negedge clk);
        chk(!done, {"R8 done single pulse ", tag}, 32'(done), 32'(0));
        chk(acc_out == 16'hFFFF, {"R4 final acc ", tag}, 32'(acc_out), 32'hFFFF);
        chk((wr_total - w0) == int'(a) + 1, {"R4 byte count ", tag}, 32'(wr_total - w0), 32'(int'(a) + 1));
        chk(x_out == ex, {"R5 final x ", tag}, 32'(x_out), 32'(ex));
        chk(y_out == ey, {"R5 final y ", tag}, 32'(y_out), 32'(ey));
    endtask

    initial begin
        cmp_on = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 reset strobes", 32'({busy, done, mem_rd, mem_wr}), 32'(0));
        chk(mem_addr == 0 && x_out == 0 && y_out == 0 && acc_out == 0 && dbank_out == 0,
            "R1 reset values", 32'(x_out), 32'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_rd && mem_addr == 0, "R1 after release", 32'(mem_addr), 32'(0));

        run_move("up",      1'b0, 1'b0, 8'h12, 8'h34, 16'h1000, 16'h2000, 16'd3, 16'h1004, 16'h2004, 1'b0);
        run_move("down",    1'b1, 1'b0, 8'h7E, 8'h01, 16'h0005, 16'h8003, 16'd2, 16'h0002, 16'h8000, 1'b0);
        // R6: offsets wrap inside the bank
        run_move("wrap up", 1'b0, 1'b0, 8'hA0, 8'hB0, 16'hFFFE, 16'hFFFF, 16'd2, 16'h0001, 16'h0002, 1'b0);
        run_move("wrap dn", 1'b1, 1'b0, 8'hC3, 8'h3C, 16'h0001, 16'h0000, 16'd2, 16'hFFFE, 16'hFFFD, 1'b0);
        // R7: narrow index, high byte cleared and low-byte wrap
        run_move("narrow",  1'b0, 1'b1, 8'h05, 8'h06, 16'h12FE, 16'h3401, 16'd2, 16'h0001, 16'h0004, 1'b0);
        run_move("narrow dn", 1'b1, 1'b1, 8'h09, 8'h0A, 16'hAB00, 16'hCD02, 16'd3, 16'h00FC, 16'h00FE, 1'b0);
        // R4: single byte copy
        run_move("single",  1'b0, 1'b0, 8'hFF, 8'h00, 16'h4444, 16'h5555, 16'd0, 16'h4445, 16'h5556, 1'b0);
        // R9: start while busy is ignored
        run_move("ignore",  1'b0, 1'b0, 8'h21, 8'h43, 16'h0100, 16'h0200, 16'd5, 16'h0106, 16'h0206, 1'b1);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule